// File: doc/BRIEF.md
# Synchronous Slave Serial Receiver

This block takes in characters on a serial data line that is timed by a clock from an external master. It never drives that clock. Each character is 8 bits, or 9 bits when nine-bit mode is selected. Bits arrive least significant first. The block moves each finished character into a two-entry receive queue.

Software reads the low 8 bits from a read port. The ninth bit of the same entry appears beside them on a separate output. A receive-complete flag, and an optional interrupt, tell the host that unread data is waiting. Because the interrupt is a plain level, it can also serve as a wake request when the rest of the system is stopped.

If a character finishes while the queue is full, the block raises an overrun error and shifts nothing more in. Dropping the receive enable or the port enable clears the error. Dropping the port enable also empties the queue.

Top module: `sync_slave_rx`

## Requirements
- R1: After reset, rx_done, overrun and irq are 0, and rd_data and rd_bit9 read 0 while the queue is empty.
- R2: Data is sampled on the active serial clock edge, least significant bit first. The edge is rising when clk_pol is 0 and falling when clk_pol is 1. The first bit received lands in rd_data[0].
- R3: When nine_bit is 1, the ninth bit received (bit 8 of the character) appears on rd_bit9 beside the 8 data bits. When nine_bit is 0, rd_bit9 reads 0.
- R4: Reception happens only while rx_en is 1. Serial edges that arrive while rx_en is 0 are ignored. Dropping rx_en throws away a partly shifted character.
- R5: single_en has no effect on reception.
- R6: The queue holds 2 characters and returns them in arrival order. A one-cycle rd_en pulse removes the head entry. A pulse of rd_en on an empty queue changes nothing.
- R7: rx_done is 1 exactly while the queue holds at least one unread entry. irq equals rx_done AND int_en.
- R8: If a character completes while the queue is full, overrun goes to 1 and that character is dropped. Later characters are ignored until overrun is cleared. Setting rx_en to 0 clears overrun and keeps the queued data.
- R9: Setting port_en to 0 empties the queue, clears overrun and discards any partly shifted character.
- R10: A completed character shows on rx_done on the third system clock edge after the active serial edge of its last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Serial port enable; 0 resets the receiver |
| rx_en | input | 1 | Continuous receive enable |
| single_en | input | 1 | Single-receive enable, ignored in slave mode |
| nine_bit | input | 1 | 1 selects 9-bit characters |
| clk_pol | input | 1 | 0 samples on the rising serial edge, 1 on the falling edge |
| int_en | input | 1 | Receive interrupt enable |
| sck | input | 1 | Serial clock from the external master |
| sdata | input | 1 | Serial data |
| rd_en | input | 1 | Pops the head queue entry |
| rd_data | output | 8 | Low 8 bits of the head entry |
| rd_bit9 | output | 1 | Ninth bit of the head entry |
| rx_done | output | 1 | Queue not empty |
| irq | output | 1 | Receive interrupt / wake request |
| overrun | output | 1 | Overrun error |

## Verification
The serial clock and data inputs each pass through two synchronizing flops before the edge register. A character therefore shows up on rx_done on the third system edge after its last active serial edge, and the latency test checks that rx_done is still 0 after two of those edges and is 1 after the third. The bench holds each serial level for three system cycles, so every character has settled before the queue is sampled. Reads and enable changes take effect one system edge later, and the bench samples at the following falling edge of clk. Overrun, flush and queue order are checked against a reference queue kept in the bench.

// File: rtl/sync_slave_rx.sv
module sync_slave_rx #(
  parameter int DW    = 8,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          port_en,
  input  logic          rx_en,
  input  logic          single_en,
  input  logic          nine_bit,
  input  logic          clk_pol,
  input  logic          int_en,
  input  logic          sck,
  input  logic          sdata,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_bit9,
  output logic          rx_done,
  output logic          irq,
  output logic          overrun
);
  localparam int WW = DW + 1;
  localparam int CW = $clog2(WW);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  logic [2:0]    sck_sy;
  logic [1:0]    sd_sy;
  logic [CW-1:0] cnt;
  logic [WW-1:0] shreg, nxt_word;
  logic [WW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [NW-1:0] count;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_sy <= '0;
      sd_sy  <= '0;
    end else begin
      sck_sy <= {sck_sy[1:0], sck};
      sd_sy  <= {sd_sy[0], sdata};
    end

  wire rise     = sck_sy[1] & ~sck_sy[2];
  wire fall     = ~sck_sy[1] & sck_sy[2];
  wire act      = clk_pol ? fall : rise;
  wire [CW-1:0] last = nine_bit ? CW'(DW) : CW'(DW - 1);
  wire shift_en  = port_en & rx_en & ~overrun & act;
  wire word_done = shift_en & (cnt == last);
  wire full      = (count == NW'(DEPTH));
  wire empty     = (count == '0);
  wire push      = word_done & ~full;
  wire pop       = port_en & rd_en & ~empty;

  always_comb begin
    nxt_word = shreg;
    nxt_word[cnt] = sd_sy[1];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt     <= '0;
      shreg   <= '0;
      overrun <= 1'b0;
    end else if (!port_en || !rx_en) begin
      cnt     <= '0;
      shreg   <= '0;
      overrun <= 1'b0;
    end else if (shift_en) begin
      if (word_done) begin
        cnt   <= '0;
        shreg <= '0;
        if (full) overrun <= 1'b1;
      end else begin
        cnt   <= cnt + 1'b1;
        shreg <= nxt_word;
      end
    end

  always_ff @(posedge clk)
    if (push) mem[wptr] <= nxt_word;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (!port_en) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count <= count + NW'(push) - NW'(pop);
    end

  assign rd_data = empty ? '0 : mem[rptr][DW-1:0];
  assign rd_bit9 = empty ? 1'b0 : mem[rptr][DW];
  assign rx_done = ~empty;
  assign irq     = rx_done & int_en;

  wire unused_ok = single_en;

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= NW'(DEPTH));
  a_r6_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && full && !rd_en) |=> full);
  a_r8_ovr_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(count) == NW'(DEPTH));
  a_r8_ovr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en || !port_en) |=> !overrun);
  a_r9_port_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (count == '0));
  a_r4_idle_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (cnt == '0));
endmodule

// File: tb/tb_sync_slave_rx.sv
module tb_sync_slave_rx;
  logic clk = 0, rst_n = 0;
  logic port_en = 1, rx_en = 1, single_en = 0, nine_bit = 0, clk_pol = 0, int_en = 0;
  logic sck = 0, sdata = 0, rd_en = 0;
  logic [7:0] rd_data;
  logic rd_bit9, rx_done, irq, overrun;

  int nchk = 0, nerr = 0;
  logic [8:0] q[$];
  bit m_ovr = 0;

  always #2 clk = ~clk;

  sync_slave_rx dut (.clk(clk), .rst_n(rst_n), .port_en(port_en), .rx_en(rx_en),
    .single_en(single_en), .nine_bit(nine_bit), .clk_pol(clk_pol), .int_en(int_en),
    .sck(sck), .sdata(sdata), .rd_en(rd_en), .rd_data(rd_data), .rd_bit9(rd_bit9),
    .rx_done(rx_done), .irq(irq), .overrun(overrun));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] expect_word(input logic [8:0] w);
    return nine_bit ? w : {1'b0, w[7:0]};
  endfunction

  task automatic send_bits(input int n, input logic [8:0] w);
    for (int i = 0; i < n; i++) begin
      sck = clk_pol; sdata = w[i]; tick(3);
      sck = ~clk_pol; tick(3);
    end
    sck = clk_pol;
  endtask

  task automatic send_word(input logic [8:0] w);
    send_bits(nine_bit ? 9 : 8, w);
    if (port_en && rx_en && !m_ovr) begin
      if (q.size() < 2) q.push_back(expect_word(w));
      else m_ovr = 1;
    end
  endtask

  task automatic check_state(input string req);
    chk({req, " R7 rx_done"}, rx_done, q.size() > 0);
    chk({req, " R7 irq"}, irq, (q.size() > 0) && int_en);
    chk({req, " R8 overrun"}, overrun, m_ovr);
  endtask

  task automatic read_one(input string req);
    if (q.size() > 0) begin
      chk({req, " R2 data"}, rd_data, q[0][7:0]);
      chk({req, " R3 bit9"}, rd_bit9, q[0][8]);
      q.pop_front();
    end
    rd_en = 1; tick(1); rd_en = 0; tick(1);
    check_state({req, " R6 after read"});
  endtask

  task automatic set_rx(input logic v);
    rx_en = v; tick(2);
    if (!v) m_ovr = 0;
  endtask

  task automatic set_port(input logic v);
    port_en = v; tick(2);
    if (!v) begin q.delete(); m_ovr = 0; end
  endtask

  task automatic set_pol(input logic p);
    set_rx(0);
    sck = p; tick(4);
    clk_pol = p; tick(1);
    set_rx(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    tick(3); rst_n = 1; tick(2);
    chk("R1 rx_done", rx_done, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 rd_bit9", rd_bit9, 0);

    // R10 latency, 8-bit 0xA5, rising edge
    int_en = 1;
    send_bits(7, 9'h0A5);
    sck = 0; sdata = 1'b1; tick(3);
    sck = 1; tick(2);
    chk("R10 not yet", rx_done, 0);
    tick(1);
    chk("R10 due", rx_done, 1);
    sck = 0;
    q.push_back(9'h0A5);
    check_state("R2");
    read_one("R2");

    // R3 nine-bit
    nine_bit = 1;
    send_word(9'h1A5); send_word(9'h05A);
    check_state("R3");
    read_one("R3"); read_one("R3");
    nine_bit = 0;
    send_word(9'h1C3);
    read_one("R3 eight-bit top bit zero");

    // R4/R5: rx_en low ignores words even with single_en
    single_en = 1; set_rx(0);
    send_word(9'h033);
    chk("R4 R5 ignored", rx_done, 0);
    set_rx(1); single_en = 0;
    // R4 partial discard
    send_bits(3, 9'h007);
    set_rx(0); set_rx(1);
    send_word(9'h096);
    read_one("R4 partial discarded");

    // R8 overrun
    send_word(9'h011); send_word(9'h022); send_word(9'h033);
    check_state("R8 set");
    send_word(9'h044);
    check_state("R8 held");
    read_one("R8 R6 order"); read_one("R8 R6 order");
    chk("R8 stays", overrun, 1);
    send_word(9'h055);
    chk("R8 blocked", rx_done, 0);
    set_rx(0);
    check_state("R8 cleared");
    set_rx(1);

    // R9 port disable flush
    send_word(9'h066); send_word(9'h077); send_word(9'h088);
    send_bits(4, 9'h00F);
    set_port(0);
    check_state("R9 flushed");
    set_port(1);
    read_one("R6 empty read");
    send_word(9'h0E1);
    read_one("R9 partial discarded");

    // falling-edge mode
    set_pol(1);
    send_word(9'h0C9);
    read_one("R2 falling");

    // random
    for (int it = 0; it < 80; it++) begin
      if ($urandom_range(0, 9) == 0) set_pol(~clk_pol);
      nine_bit  = $urandom_range(0, 1);
      int_en    = $urandom_range(0, 1);
      single_en = $urandom_range(0, 1);
      send_word(9'($urandom));
      check_state("rand");
      for (int r = $urandom_range(0, 2); r > 0; r--) read_one("rand R6");
      if (m_ovr && $urandom_range(0, 1)) set_rx(0);
      if (!rx_en) set_rx(1);
      if ($urandom_range(0, 19) == 0) begin set_port(0); set_port(1); check_state("rand R9"); end
    end
    while (q.size() > 0) read_one("drain R6");

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule